// File: doc/BRIEF.md
# Delay-Line Tap-Read DMA Engine

This engine gathers samples from a circular delay line held in external memory and packs them into a linear buffer in internal memory. A tap list in internal memory supplies one signed offset per tap. For each tap the engine works out where that tap starts in the delay line, relative to the current delay-line index and wrapped inside the buffer. It then reads a fixed number of consecutive 32-bit words from that point. Reads that run past the end of the buffer continue from its base. Every word read is stored at the internal destination pointer, and the pointer then moves on by its modifier.

The only way to start the engine is to load a parameter block from internal memory. A start pulse supplies the block's address. When the last read of the last tap has been stored, the engine finishes the block. A zero chain pointer ends the run. A nonzero chain pointer makes the engine fetch the next block from that address and carry on without dropping busy. The completion interrupt is a one-cycle pulse. A single run always raises it. In a chained run it is raised only for blocks whose interrupt-enable bit is set.

Both memory sides use a simple request/ready handshake. A request and its address stay stable until ready is seen high at a clock edge. On the internal side, read data is taken in the same cycle that ready is high. On the external side, read data is likewise valid in the cycle that ready is high.

Top module: `dltap_dma`

## Requirements
- R1: During reset and immediately after it, busy, irq, im_req and em_req are all low.
- R2: A start pulse while idle fetches an 11-word parameter block from consecutive internal addresses starting at pb_addr. The word layout is:
  - +0: destination pointer
  - +1: destination modifier
  - +2: delay-line index
  - +3: delay-line base
  - +4: delay-line length
  - +5: tap-list pointer
  - +6: tap-list modifier
  - +7: tap count
  - +8: reads per tap
  - +9: chain pointer
  - +10: bit 0 is interrupt enable

  Busy is high from the cycle after the start pulse until completion.
- R3: Each tap entry is read from the tap-list pointer, and the pointer then advances by the tap-list modifier. Each tap produces exactly the "reads per tap" number of external reads. A block therefore makes 11 plus tap-count internal reads.
- R4: The first read of a tap goes to base + ((index + offset) mod length), where the offset is the tap word taken as a two's-complement number whose magnitude is below the length. Each following read of that tap uses the next position, and position length wraps back to 0.
- R5: Each external word is written unchanged to the destination pointer. The pointer then advances by the destination modifier after every word and is not reset between taps.
- R6: After the final read of the final tap has been written, irq pulses for exactly one cycle. For a run that ends there, busy is low in the cycle after the pulse.
- R7: A chain pointer of zero ends the run with no further parameter-block fetch.
- R8: A nonzero chain pointer makes the engine fetch the next block from that address after completion. Busy stays high across the chain.
- R9: When the chain pointer is nonzero, irq pulses at that block's completion only if its interrupt-enable bit is 1. When the chain pointer is zero, irq always pulses.
- R10: A start pulse that arrives while busy is ignored and does not change the transfer in progress.
- R11: A tap count of zero completes the block with no external reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| pb_addr | input | IAW | Internal address of the first parameter block |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle completion interrupt |
| im_req | output | 1 | Internal memory request |
| im_we | output | 1 | Internal request is a write |
| im_addr | output | IAW | Internal memory address |
| im_wdata | output | DW | Internal write data |
| im_rdata | input | DW | Internal read data, valid with im_ready |
| im_ready | input | 1 | Internal request accepted this cycle |
| em_req | output | 1 | External read request |
| em_addr | output | EAW | External read address |
| em_rdata | input | DW | External read data, valid with em_ready |
| em_ready | input | 1 | External read completes this cycle |

## Verification
The hardest condition to reach is a tap whose burst crosses the end of the delay line, while both memories stall and while a chained block hands over without busy dropping. The stimulus gets there with three tap sets:
- one with offsets that land near the buffer end and a burst longer than the remaining space;
- one with a positive offset that itself wraps past the length;
- a two-block chain run with ready throttled on both sides.

A start pulse is also injected halfway through a run that points at a different block. The reference model's address stream must still match word for word.

// File: rtl/dltap_dma.sv
module dltap_dma #(
  parameter int DW  = 32,
  parameter int IAW = 16,
  parameter int EAW = 16,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [IAW-1:0] pb_addr,
  output logic           busy,
  output logic           irq,
  output logic           im_req,
  output logic           im_we,
  output logic [IAW-1:0] im_addr,
  output logic [DW-1:0]  im_wdata,
  input  logic [DW-1:0]  im_rdata,
  input  logic           im_ready,
  output logic           em_req,
  output logic [EAW-1:0] em_addr,
  input  logic [DW-1:0]  em_rdata,
  input  logic           em_ready
);

  localparam int PBW   = 11;
  localparam int KW    = $clog2(PBW);
  localparam int SW    = EAW + 2;
  localparam logic [KW-1:0] LASTK = KW'(PBW - 1);

  typedef enum logic [2:0] {S_IDLE, S_PB, S_TAP, S_READ, S_WR, S_NEXT, S_DONE} st_t;

  st_t            state;
  logic [KW-1:0]  k;
  logic [IAW-1:0] pb_ptr, dptr, dmod, tptr, tmod, chain;
  logic [EAW-1:0] eidx, ebase, elen, pos;
  logic [CW-1:0]  tcnt, rcnt, rload;
  logic           ie;
  logic [DW-1:0]  dbuf;

  logic signed [SW-1:0] tap_sum, len_s, tap_wr;
  logic [EAW:0]         pos_p1;
  logic [EAW-1:0]       pos_nx;
  logic                 unused_bits;

  assign len_s   = $signed({2'b00, elen});
  assign tap_sum = $signed({2'b00, eidx}) + $signed(im_rdata[SW-1:0]);
  assign tap_wr  = (tap_sum < 0) ? tap_sum + len_s :
                   (tap_sum >= len_s) ? tap_sum - len_s : tap_sum;
  assign pos_p1  = {1'b0, pos} + (EAW+1)'(1);
  assign pos_nx  = (pos_p1 == {1'b0, elen}) ? '0 : pos_p1[EAW-1:0];
  assign unused_bits = ^{im_rdata[DW-1:SW], tap_wr[SW-1:EAW]};

  assign busy     = (state != S_IDLE);
  assign irq      = (state == S_DONE) && ((chain == '0) || ie);
  assign im_req   = (state == S_PB) || (state == S_TAP) || (state == S_WR);
  assign im_we    = (state == S_WR);
  assign im_wdata = dbuf;
  assign em_req   = (state == S_READ);
  assign em_addr  = ebase + pos;

  always_comb begin
    case (state)
      S_PB:    im_addr = pb_ptr + IAW'(k);
      S_TAP:   im_addr = tptr;
      S_WR:    im_addr = dptr;
      default: im_addr = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      k      <= '0;
      pb_ptr <= '0;
      dptr   <= '0;
      dmod   <= '0;
      tptr   <= '0;
      tmod   <= '0;
      chain  <= '0;
      eidx   <= '0;
      ebase  <= '0;
      elen   <= '0;
      pos    <= '0;
      tcnt   <= '0;
      rcnt   <= '0;
      rload  <= '0;
      ie     <= 1'b0;
      dbuf   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          pb_ptr <= pb_addr;
          k      <= '0;
          rcnt   <= '0;
          state  <= S_PB;
        end
        S_PB: if (im_ready) begin
          case (k)
            KW'(0):  dptr  <= im_rdata[IAW-1:0];
            KW'(1):  dmod  <= im_rdata[IAW-1:0];
            KW'(2):  eidx  <= im_rdata[EAW-1:0];
            KW'(3):  ebase <= im_rdata[EAW-1:0];
            KW'(4):  elen  <= im_rdata[EAW-1:0];
            KW'(5):  tptr  <= im_rdata[IAW-1:0];
            KW'(6):  tmod  <= im_rdata[IAW-1:0];
            KW'(7):  tcnt  <= im_rdata[CW-1:0];
            KW'(8):  rload <= im_rdata[CW-1:0];
            KW'(9):  chain <= im_rdata[IAW-1:0];
            default: ie    <= im_rdata[0];
          endcase
          k <= k + KW'(1);
          if (k == LASTK) state <= S_NEXT;
        end
        S_TAP: if (im_ready) begin
          pos   <= tap_wr[EAW-1:0];
          tptr  <= tptr + tmod;
          tcnt  <= tcnt - CW'(1);
          rcnt  <= rload;
          state <= S_NEXT;
        end
        S_READ: if (em_ready) begin
          dbuf  <= em_rdata;
          pos   <= pos_nx;
          rcnt  <= rcnt - CW'(1);
          state <= S_WR;
        end
        S_WR: if (im_ready) begin
          dptr  <= dptr + dmod;
          state <= S_NEXT;
        end
        S_NEXT: begin
          if (rcnt != '0)      state <= S_READ;
          else if (tcnt != '0) state <= S_TAP;
          else                 state <= S_DONE;
        end
        S_DONE: begin
          if (chain != '0) begin
            pb_ptr <= chain;
            k      <= '0;
            rcnt   <= '0;
            state  <= S_PB;
          end else begin
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dltap_dma_chk.sv
module dltap_dma_chk #(
  parameter int IAW = 16,
  parameter int EAW = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           busy,
  input logic           irq,
  input logic           im_req,
  input logic           im_we,
  input logic           im_ready,
  input logic [IAW-1:0] im_addr,
  input logic           em_req,
  input logic           em_ready,
  input logic [EAW-1:0] em_addr,
  input logic [EAW-1:0] ebase,
  input logic [EAW-1:0] elen
);

  assert_one_side_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(im_req && em_req));

  assert_em_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    em_req |-> (EAW'(em_addr - ebase) < elen));

  assert_em_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (em_req && !em_ready) |=> (em_req && $stable(em_addr)));

  assert_im_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (im_req && !im_ready) |=> (im_req && $stable(im_addr) && $stable(im_we)));

  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> busy);

  assert_busy_ends_with_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(irq));

endmodule

bind dltap_dma dltap_dma_chk #(.IAW(IAW), .EAW(EAW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq),
  .im_req(im_req), .im_we(im_we), .im_ready(im_ready), .im_addr(im_addr),
  .em_req(em_req), .em_ready(em_ready), .em_addr(em_addr),
  .ebase(ebase), .elen(elen)
);

// File: tb/dltap_dma_tb_top.sv
module dltap_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] pb_addr = '0;
  logic        busy, irq, im_req, im_we, im_ready, em_req, em_ready;
  logic [15:0] im_addr, em_addr;
  logic [31:0] im_wdata, im_rdata, em_rdata;

  logic [31:0] imem [0:255];
  logic        stall = 1'b0;
  int          cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign im_ready = !stall || (cyc % 3 != 1);
  assign em_ready = !stall || (cyc % 2 == 0);
  assign im_rdata = imem[im_addr[7:0]];
  assign em_rdata = {16'hA500, em_addr};

  dltap_dma dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pb_addr(pb_addr),
    .busy(busy), .irq(irq),
    .im_req(im_req), .im_we(im_we), .im_addr(im_addr), .im_wdata(im_wdata),
    .im_rdata(im_rdata), .im_ready(im_ready),
    .em_req(em_req), .em_addr(em_addr), .em_rdata(em_rdata), .em_ready(em_ready)
  );

  int checks = 0, fails = 0;
  int irq_cnt, imrd_cnt, fall_cnt, exp_irq, exp_imrd;
  bit irq_prev = 0, busy_prev = 0, fin = 0;
  logic [15:0] exp_ea[$];
  logic [15:0] exp_wa[$];
  logic [31:0] exp_wd[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setup_block(input int pb, input int dptr, input int dmod, input int eidx,
                             input int ebase, input int elen, input int tptr, input int tmod,
                             input int offs[$], input int rc, input int chain, input int ie);
    int d;
    imem[pb+0] = dptr;  imem[pb+1] = dmod;  imem[pb+2] = eidx;
    imem[pb+3] = ebase; imem[pb+4] = elen;  imem[pb+5] = tptr;
    imem[pb+6] = tmod;  imem[pb+7] = offs.size(); imem[pb+8] = rc;
    imem[pb+9] = chain; imem[pb+10] = ie;
    d = dptr;
    foreach (offs[t]) begin
      int s;
      imem[(tptr + t*tmod) & 255] = offs[t];
      s = ((eidx + offs[t]) % elen + elen) % elen;
      for (int r = 0; r < rc; r++) begin
        exp_ea.push_back(16'(ebase + s));
        exp_wa.push_back(16'(d));
        exp_wd.push_back({16'hA500, 16'(ebase + s)});
        d += dmod;
        s = (s + 1) % elen;
      end
    end
    exp_imrd += 11 + offs.size();
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_prev) chk(busy == (irq_cnt < exp_irq), "R6", busy, irq_cnt < exp_irq);
      irq_prev = irq;
      if (irq) irq_cnt++;
      if (busy_prev && !busy) fall_cnt++;
      busy_prev = busy;
      if (em_req && em_ready) begin
        if (exp_ea.size() == 0) chk(0, "R3", em_addr, 0);
        else begin
          logic [15:0] e;
          e = exp_ea.pop_front();
          chk(em_addr == e, "R4", em_addr, e);
        end
      end
      if (im_req && im_we && im_ready) begin
        if (exp_wa.size() == 0) chk(0, "R5", im_addr, 0);
        else begin
          logic [15:0] a;
          logic [31:0] w;
          a = exp_wa.pop_front();
          w = exp_wd.pop_front();
          chk(im_addr == a, "R5", im_addr, a);
          chk(im_wdata == w, "R5", im_wdata, w);
        end
      end
      if (im_req && !im_we && im_ready) imrd_cnt++;
    end
  end

  task automatic prep(input int n_irq);
    irq_cnt = 0; imrd_cnt = 0; fall_cnt = 0; exp_imrd = 0; exp_irq = n_irq;
  endtask

  task automatic kick(input int pb);
    @(negedge clk); start = 1'b1; pb_addr = 16'(pb);
    @(negedge clk); start = 1'b0; pb_addr = '0;
    chk(busy == 1'b1, "R2", busy, 1);
  endtask

  task automatic wait_done(input string tag);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(exp_ea.size() == 0, "R3", exp_ea.size(), 0);
    chk(irq_cnt == exp_irq, "R9", irq_cnt, exp_irq);
    chk(imrd_cnt == exp_imrd, "R7", imrd_cnt, exp_imrd);
    chk(fall_cnt == 1, "R8", fall_cnt, 1);
    $display("done %s", tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int q[$];
    for (int i = 0; i < 256; i++) imem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !im_req && !em_req, "R1", {busy, irq, im_req, em_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !irq && !im_req && !em_req, "R1", {busy, irq, im_req, em_req}, 0);

    // R4 R5 R6 R7: burst wraps past buffer end, single run without enable
    prep(1);
    q = {-2, -5, 14};
    setup_block(16'h10, 16'h200, 1, 3, 16'h1000, 16, 16'h40, 1, q, 4, 0, 0);
    kick(16'h10);
    wait_done("single");

    // R3 R4 R5: stalls, strided tap list and destination
    stall = 1'b1;
    prep(1);
    q = {0, 5, -1};
    setup_block(16'h80, 16'h300, 3, 10, 16'h2000, 12, 16'h50, 2, q, 3, 0, 1);
    kick(16'h80);
    wait_done("stalled");

    // R8 R9: chain, first block enable low, second ends the run
    prep(1);
    q = {1, -3};
    setup_block(16'h20, 16'h400, 1, 7, 16'h3000, 9, 16'h90, 1, q, 5, 16'h30, 0);
    q = {-8};
    setup_block(16'h30, 16'h500, 2, 2, 16'h3100, 8, 16'hA0, 1, q, 2, 0, 0);
    kick(16'h20);
    wait_done("chain_ie0");

    // R9: chain with enable set gives two pulses, busy held between
    stall = 1'b0;
    prep(2);
    q = {4};
    setup_block(16'h60, 16'h600, 1, 0, 16'h4000, 5, 16'hB0, 1, q, 6, 16'h70, 1);
    q = {-1, 2};
    setup_block(16'h70, 16'h610, 1, 1, 16'h4100, 3, 16'hB8, 1, q, 1, 0, 0);
    kick(16'h60);
    wait_done("chain_ie1");

    // R11: zero taps
    prep(1);
    q = {};
    setup_block(16'hC0, 16'h700, 1, 0, 16'h5000, 4, 16'hD0, 1, q, 3, 0, 0);
    kick(16'hC0);
    wait_done("no_taps");

    // R10: start while busy points at another block and must be ignored
    prep(1);
    q = {-2, -5, 14};
    setup_block(16'h10, 16'h200, 1, 3, 16'h1000, 16, 16'h40, 1, q, 4, 0, 0);
    kick(16'h10);
    repeat (12) @(negedge clk);
    chk(busy == 1'b1, "R10", busy, 1);
    start = 1'b1; pb_addr = 16'h20;
    @(negedge clk); start = 1'b0; pb_addr = '0;
    wait_done("restart_ignored");
    chk(!busy && !im_req && !em_req, "R10", {busy, im_req, em_req}, 0);

    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule